// File: doc/BRIEF.md
# Programmable Clock Output Stage

This block forms the last stage of a clock generator. It receives edge strobes from two free-running sources, a synthesizer clock and a reference clock. Each strobe marks one half-period of its source. The block picks one source and divides it by a power of two from 1 to 128. It then gates the divided clock with an active-low control pin. Static configuration inputs set how that pin behaves. In output-enable mode, a low pin stops the output while the divider keeps counting, so the output returns quickly. In power-down mode, a low pin also holds the divider in reset, and the output cannot return until a relock wait has counted a set number of source half-periods.

Stopping the output can happen in one of two ways: at once (asynchronous), or at the next falling edge of the divided clock (synchronous). Starting the output always waits for a falling-edge boundary, so the first thing seen on the pin is a full low phase. A change to the source or divide code while the output runs is applied in three steps: the stage first gates the output low at a falling edge, then loads the new setting, then restarts the divider. The pad tri-state enable and a live status flag are provided next to the gated clock.

Top module: `clkout_stage`

## Requirements
- R1: With divide code `divCode` = k (0..7), the output high phase and low phase each last 2^k selected source strobes. This gives ratios 1, 2, 4, 8, 16, 32, 64 and 128.
- R2: `srcSel` = 0 divides the strobes on `pllTick`, and `srcSel` = 1 divides the strobes on `refTick`.
- R3: With `asyncDisable` = 1, a low `ctrlN` forces `clkOut` and `outEnable` to 0 in the same cycle, whatever the output level was.
- R4: With `asyncDisable` = 0, a low `ctrlN` lets the high phase in progress finish at its full width. The output then stays low and produces no further pulse.
- R5: After `ctrlN` returns high, the output resumes only at a falling boundary of the divided clock. It starts with a full low phase, and its first high pulse has full width.
- R6: `outEnable` and `outLive` are 1 while the gated output runs and 0 while it is disabled.
- R7: With `pwrDownMode` = 1, after `ctrlN` is released the output does not come back before `LOCK_CYCLES` selected source strobes have elapsed. It also stays dark (`outLive` = 0) for as long as `ctrlN` is low.
- R8: With `pwrDownMode` = 0, the output returns within two divided output periods plus a few cycles after `ctrlN` is released.
- R9: A change of `srcSel` or `divCode` while the output runs produces no high pulse shorter than the shorter of the old and new high widths. After the change, the output settles to the new ratio.
- R10: During reset and in the first cycle after it, `clkOut`, `outEnable` and `outLive` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock on which source strobes are sampled |
| rstN | input | 1 | Active-low synchronous reset |
| pllTick | input | 1 | Half-period strobe of the synthesizer source |
| refTick | input | 1 | Half-period strobe of the reference source |
| srcSel | input | 1 | Source choice: 0 synthesizer, 1 reference |
| divCode | input | CODE_W | Divide exponent, ratio is 2^divCode |
| ctrlN | input | 1 | Active-low output control pin |
| pwrDownMode | input | 1 | 1: pin acts as power-down with relock wait; 0: output enable |
| asyncDisable | input | 1 | 1: stop immediately; 0: stop at next falling output edge |
| clkOut | output | 1 | Gated divided clock |
| outEnable | output | 1 | Pad drive enable, 0 means tri-state with weak pull-down |
| outLive | output | 1 | Status: gated output is running |

## Verification
The hardest situation to reach from the ports is a disable or reconfiguration that lands in the middle of a long high phase. That is the only moment where a runt pulse or a truncated phase could appear. The stimulus watches `clkOut` until it sees a fresh rising edge, then drops `ctrlN` or changes the divide code on the next cycle. A monitor records every high and low run, so truncated pulses show up as widths below the expected value. Random rounds combine source, ratio, timing mode, power mode and short control toggles. Directed rounds measure the relock latency against the configured lock length.

// File: rtl/clkout_stage_pkg.sv
package clkout_stage_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic setGate;   // open the output gate (only at a falling boundary)
    logic clrGate;   // close the output gate
    logic loadCfg;   // take the pending source/divide setting
    logic holdDiv;   // keep divider in reset (power-down / relock)
  } gateCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_SLEEP  = 2'd2,
    ST_RELOCK = 2'd3
  } ctlState_t;

endpackage

// File: rtl/clkout_stage_sync.sv
module clkout_stage_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/clkout_stage_datapath.sv
module clkout_stage_datapath
  import clkout_stage_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pllTick,
  input  logic              refTick,
  input  logic              srcSelIn,
  input  logic [CODE_W-1:0] divCodeIn,
  input  logic              ctrlN,
  input  logic              asyncDisable,
  input  gateCmd_t          cmd,
  output logic              selTick,
  output logic              fallEdge,
  output logic              cfgPending,
  output logic              gateOn,
  output logic              clkOut,
  output logic              outEnable
);

  localparam int MAX_SHIFT = (1 << CODE_W) - 1;
  localparam int CNT_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic              cfgSrc;
  logic [CODE_W-1:0] cfgDiv;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic              divClk;
  logic              wrap;
  logic              killNow;

  // Terminal count is 2^code - 1, built as a mask
  assign limit      = ~({CNT_W{1'b1}} << cfgDiv);
  assign selTick    = cfgSrc ? refTick : pllTick;
  assign wrap       = selTick && (cnt == limit);
  assign fallEdge   = wrap && divClk;
  assign cfgPending = (srcSelIn != cfgSrc) || (divCodeIn != cfgDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSrc <= 1'b0;
      cfgDiv <= '0;
      cnt    <= '0;
      divClk <= 1'b0;
    end else if (cmd.loadCfg) begin
      cfgSrc <= srcSelIn;
      cfgDiv <= divCodeIn;
      cnt    <= '0;
      divClk <= 1'b0;
    end else if (cmd.holdDiv) begin
      cnt    <= '0;
      divClk <= 1'b0;
    end else if (selTick) begin
      if (cnt == limit) begin
        cnt    <= '0;
        divClk <= ~divClk;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            gateOn <= 1'b0;
    else if (cmd.clrGate) gateOn <= 1'b0;
    else if (cmd.setGate) gateOn <= 1'b1;
  end

  // Immediate stop path works from the raw pin, bypassing the synchronizer
  assign killNow   = asyncDisable && !ctrlN;
  assign clkOut    = divClk && gateOn && !killNow;
  assign outEnable = gateOn && !killNow;

  assert_start_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> !divClk);

  assert_cfg_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({cfgSrc, cfgDiv}) |-> !$past(gateOn));

  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= limit);

endmodule

// File: rtl/clkout_stage_control.sv
module clkout_stage_control
  import clkout_stage_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ctrlReq,
  input  logic     pwrDownMode,
  input  logic     asyncDisable,
  input  logic     selTick,
  input  logic     fallEdge,
  input  logic     cfgPending,
  input  logic     gateOn,
  output gateCmd_t cmd
);

  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_CYCLES - 1);

  ctlState_t         state, nextState;
  logic [LOCK_W-1:0] lockCnt, lockNext;

  always_comb begin
    cmd       = '0;
    nextState = state;
    lockNext  = lockCnt;
    case (state)
      ST_IDLE: begin
        if (!ctrlReq && pwrDownMode) begin
          nextState = ST_SLEEP;
        end else if (cfgPending) begin
          cmd.loadCfg = 1'b1;
        end else if (ctrlReq && fallEdge) begin
          cmd.setGate = 1'b1;
          nextState   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!ctrlReq && asyncDisable) begin
          cmd.clrGate = 1'b1;
          nextState   = ST_IDLE;
        end else if ((!ctrlReq || cfgPending) && fallEdge) begin
          cmd.clrGate = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      ST_SLEEP: begin
        cmd.holdDiv = 1'b1;
        if (ctrlReq) begin
          nextState = ST_RELOCK;
          lockNext  = '0;
        end else if (!pwrDownMode) begin
          nextState = ST_IDLE;
        end
      end
      ST_RELOCK: begin
        cmd.holdDiv = 1'b1;
        if (!ctrlReq) begin
          nextState = ST_SLEEP;
        end else if (selTick) begin
          if (lockCnt == LOCK_LAST) nextState = ST_IDLE;
          else                      lockNext  = lockCnt + 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      lockCnt <= '0;
    end else begin
      state   <= nextState;
      lockCnt <= lockNext;
    end
  end

  assert_cmd_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.setGate, cmd.clrGate, cmd.loadCfg}));

  assert_sync_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gateOn) && !$past(asyncDisable)) |-> $past(fallEdge));

  assert_rise_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOn) |-> $past(fallEdge && ctrlReq));

  assert_sleep_dark_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP || state == ST_RELOCK) |-> !gateOn);

  assert_relock_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELOCK && $past(state) == ST_SLEEP) |-> lockCnt == '0);

endmodule

// File: rtl/clkout_stage.sv
module clkout_stage
  import clkout_stage_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int LOCK_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pllTick,
  input  logic              refTick,
  input  logic              srcSel,
  input  logic [CODE_W-1:0] divCode,
  input  logic              ctrlN,
  input  logic              pwrDownMode,
  input  logic              asyncDisable,
  output logic              clkOut,
  output logic              outEnable,
  output logic              outLive
);

  gateCmd_t cmd;
  logic     ctrlReq;
  logic     selTick;
  logic     fallEdge;
  logic     cfgPending;
  logic     gateOn;

  clkout_stage_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (ctrlN),
    .syncOut (ctrlReq)
  );

  clkout_stage_control #(.LOCK_CYCLES(LOCK_CYCLES)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .ctrlReq      (ctrlReq),
    .pwrDownMode  (pwrDownMode),
    .asyncDisable (asyncDisable),
    .selTick      (selTick),
    .fallEdge     (fallEdge),
    .cfgPending   (cfgPending),
    .gateOn       (gateOn),
    .cmd          (cmd)
  );

  clkout_stage_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pllTick      (pllTick),
    .refTick      (refTick),
    .srcSelIn     (srcSel),
    .divCodeIn    (divCode),
    .ctrlN        (ctrlN),
    .asyncDisable (asyncDisable),
    .cmd          (cmd),
    .selTick      (selTick),
    .fallEdge     (fallEdge),
    .cfgPending   (cfgPending),
    .gateOn       (gateOn),
    .clkOut       (clkOut),
    .outEnable    (outEnable)
  );

  assign outLive = gateOn;

endmodule

// File: tb/clkout_stage_tb.sv
module clkout_stage_tb;

  localparam int CODE_W = 3;
  localparam int LOCK   = 40;
  localparam int REFGAP = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pllTick = 1'b1;
  logic              refTick;
  logic              srcSel = 1'b0;
  logic [CODE_W-1:0] divCode = '0;
  logic              ctrlN = 1'b1;
  logic              pwrDownMode = 1'b0;
  logic              asyncDisable = 1'b0;
  logic              clkOut, outEnable, outLive;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  clkout_stage #(.CODE_W(CODE_W), .LOCK_CYCLES(LOCK), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .pllTick(pllTick), .refTick(refTick),
    .srcSel(srcSel), .divCode(divCode), .ctrlN(ctrlN),
    .pwrDownMode(pwrDownMode), .asyncDisable(asyncDisable),
    .clkOut(clkOut), .outEnable(outEnable), .outLive(outLive)
  );

  always #2 clk = ~clk;

  int refPh = 0;
  always @(posedge clk) refPh <= (refPh == REFGAP - 1) ? 0 : refPh + 1;
  assign refTick = (refPh == 0);

  // Run-length monitor on the output pin
  int hiRun = 0, loRun = 0, lastHi = 0, lastLo = 0, hiCount = 0;
  int minHi = 1 << 30;
  always @(negedge clk) begin
    if (clkOut) begin
      hiRun++;
      if (loRun > 0) begin lastLo = loRun; loRun = 0; end
    end else begin
      loRun++;
      if (hiRun > 0) begin
        lastHi = hiRun;
        hiCount++;
        if (hiRun < minHi) minHi = hiRun;
        hiRun = 0;
      end
    end
  end

  function automatic int expW(bit src, int code);
    return (1 << code) * (src ? REFGAP : 1);
  endfunction

  task automatic checkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkRange(string tag, int act, int lo, int hi);
    nChecks++;
    if (act < lo || act > hi) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic waitPulses(int n);
    int start = hiCount;
    for (int g = 0; g < 8000 && hiCount < start + n; g++) tick();
  endtask

  task automatic waitRise();
    bit prev = clkOut;
    for (int g = 0; g < 4000; g++) begin
      tick();
      if (clkOut && !prev) break;
      prev = clkOut;
    end
  endtask

  task automatic measureLive(output int lat);
    lat = 0;
    for (int g = 0; g < 4000 && !outLive; g++) begin
      tick();
      lat++;
    end
  endtask

  task automatic setCfg(bit s, int c);
    srcSel  = s;
    divCode = CODE_W'(c);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int lat, riseLat, liveLat, w, pw, start;
    int unsigned seedVal;
    seedVal = $urandom(32'd4242);

    // R10: reset state
    repeat (5) tick();
    checkEq("R10 clkOut in reset", int'(clkOut), 0);
    checkEq("R10 outEnable in reset", int'(outEnable), 0);
    checkEq("R10 outLive in reset", int'(outLive), 0);
    rstN = 1'b1;
    tick();
    checkEq("R10 outLive after reset", int'(outLive), 0);
    checkEq("R10 clkOut after reset", int'(clkOut), 0);

    // R1/R2: all sixteen source/ratio options, R9 glitch bound on each change
    pw = expW(0, 0);
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        w = expW(s[0], c);
        minHi = 1 << 30;
        setCfg(s[0], c);
        waitPulses(4);
        checkEq(s ? "R2 ref high width" : "R1 pll high width", lastHi, w);
        checkEq(s ? "R2 ref low width" : "R1 pll low width", lastLo, w);
        checkRange("R9 no runt on change", minHi, (pw < w) ? pw : w, 1 << 30);
        checkEq("R6 outEnable while live", int'(outEnable), 1);
        pw = w;
      end
    end

    // R3: immediate stop mid high phase
    setCfg(0, 4);
    w = expW(0, 4);
    asyncDisable = 1'b1;
    waitPulses(3);
    waitRise();
    tick();
    ctrlN = 1'b0;
    #1;
    checkEq("R3 clkOut forced low", int'(clkOut), 0);
    checkEq("R3 outEnable forced low", int'(outEnable), 0);
    repeat (10) tick();
    checkEq("R6 outLive after stop", int'(outLive), 0);
    // R5/R8: return aligned to falling boundary
    ctrlN = 1'b1;
    riseLat = 0; liveLat = -1;
    for (int g = 0; g < 4000 && !clkOut; g++) begin
      tick();
      riseLat++;
      if (outLive && liveLat < 0) liveLat = riseLat;
    end
    checkRange("R5 first rise after full low", riseLat, w, 3 * w + 8);
    checkRange("R8 quick return", liveLat, 1, 2 * w + 6);
    waitPulses(1);
    checkEq("R5 first pulse width", lastHi, w);

    // R4: stop aligned to falling edge
    asyncDisable = 1'b0;
    setCfg(0, 3);
    w = expW(0, 3);
    waitPulses(4);
    waitRise();
    ctrlN = 1'b0;
    waitPulses(1);
    checkEq("R4 last pulse full width", lastHi, w);
    start = hiCount;
    repeat (40) tick();
    checkEq("R4 no pulse after stop", hiCount, start);
    checkEq("R6 outEnable disabled", int'(outEnable), 0);
    checkEq("R6 outLive disabled", int'(outLive), 0);
    ctrlN = 1'b1;
    waitPulses(1);
    checkEq("R5 first pulse after sync restart", lastHi, w);

    // R7: power-down relock wait, both sources
    pwrDownMode = 1'b1;
    for (int s = 0; s < 2; s++) begin
      setCfg(s[0], 0);
      waitPulses(4);
      ctrlN = 1'b0;
      repeat (20) tick();
      checkEq("R7 dark while low", int'(outLive), 0);
      checkEq("R7 pad off while low", int'(outEnable), 0);
      ctrlN = 1'b1;
      measureLive(lat);
      checkRange("R7 relock latency", lat, LOCK * (s ? REFGAP : 1),
                 LOCK * (s ? REFGAP : 1) + 8 * (s ? REFGAP : 1) + 6);
    end

    // R8: output-enable mode returns without relock
    pwrDownMode = 1'b0;
    setCfg(0, 0);
    waitPulses(4);
    ctrlN = 1'b0;
    repeat (20) tick();
    ctrlN = 1'b1;
    measureLive(lat);
    checkRange("R8 oe latency", lat, 1, 8);

    // Random rounds
    pw = expW(0, 0);
    for (int it = 0; it < 24; it++) begin
      bit rs, ra, rp, rt;
      int rc;
      rs = 1'($urandom % 2);
      rc = int'($urandom % 5);
      ra = 1'($urandom % 2);
      rp = 1'($urandom % 2);
      rt = 1'($urandom % 2);
      w  = expW(rs, rc);
      asyncDisable = ra;
      pwrDownMode  = rp;
      minHi = 1 << 30;
      setCfg(rs, rc);
      if (rt) begin
        waitPulses(1);
        ctrlN = 1'b0;
        repeat (1 + ($urandom % 20)) tick();
        ctrlN = 1'b1;
      end
      waitPulses(3);
      checkEq(rs ? "R2 random high" : "R1 random high", lastHi, w);
      checkEq(rs ? "R2 random low" : "R1 random low", lastLo, w);
      if (!ra || !rt)
        checkRange("R9 random no runt", minHi, (pw < w) ? pw : w, 1 << 30);
      pw = w;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule